// File: doc/BRIEF.md
# ULPI PHY Reset and Interface Safeguard Sequencer

This block sits on the PHY side of a ULPI link. It orders the start-up and reset behaviour of the link-facing pins. Three reset sources are handled, each with its own side effects:

- **Power-on reset.** Tri-states the ULPI outputs and turns every pull off.
- **External reset pin.** Must stay low for a minimum number of reference-clock cycles. It returns the register file to its defaults, holds the PHY clock and drives DIR high with the protection pulls on.
- **Software reset.** Clears only the core logic for a fixed number of cycles. The clock keeps running and the register file is untouched.

After a hardware reset, the block waits for the PLL to report lock. It then enables the output clock and releases DIR.

The block also owns the holding state. This state is entered during reset, and whenever the link keeps STP high on two consecutive clock samples. While holding, bus commands (register-write strobes included) are ignored. If protection has not been disabled, the data-line pull-downs and the STP pull-up are enabled while holding. A protect-disable write switches those pulls off until the next hardware reset. During normal operation, DIR and NXT follow the requests of the packet layer, and NXT is gated while holding.

All inputs are assumed synchronous to `clk_i`. The power-on-reset input also acts as the block's synchronous active-high reset.

Top module: `ulpi_rst_guard`

## Requirements
- R1: One clock edge after `por_i` is sampled high, `ulpi_hiz_o`=1, `dpd_en_o`=0, `stp_pu_en_o`=0, `reg_rst_o`=1, `core_rst_o`=1, `clk_en_o`=0, `cmd_en_o`=0. This holds for as long as `por_i` stays high. The power-on reset takes priority over every other source.
- R2: A low pulse on `pin_rst_n_i` covering fewer than MIN_RST consecutive clock samples has no effect on any output.
- R3: On the MIN_RST-th consecutive low sample of `pin_rst_n_i`, a pin reset starts and outputs `dir_o`=1, `nxt_o`=0, `clk_en_o`=0, `dpd_en_o`=1, `stp_pu_en_o`=1, `ulpi_hiz_o`=0, `reg_rst_o`=1, `core_rst_o`=1, `cmd_en_o`=0. These hold while the pin stays low. A pin reset overrides a running software reset.
- R4: After a hardware reset ends, `reg_rst_o` falls and the block waits with `dir_o`=1, `clk_en_o`=0, `core_rst_o`=1 and the pulls on. On the edge that samples `pll_locked_i` high, it enters normal operation with `clk_en_o`=1 and `core_rst_o`=0.
- R5: Normal operation starts in the holding state (`cmd_en_o`=0). The holding state is left on the first edge that samples `stp_i` low, and `cmd_en_o`=1 from then on.
- R6: Outside holding, `stp_i` sampled high on two consecutive edges enters holding after the second edge. A single-cycle STP pulse does not.
- R7: While holding, `swrst_wr_i` and `prot_off_wr_i` are ignored.
- R8: An accepted `prot_off_wr_i` makes `dpd_en_o` and `stp_pu_en_o` stay 0 in later holding states, until the next pin or power-on reset restores protection.
- R9: An accepted `swrst_wr_i` starts a software reset that lasts exactly SW_CYCLES cycles. During it, `dir_o`=1, `dpd_en_o`=1, `core_rst_o`=1, `clk_en_o`=1 and `reg_rst_o`=0. The protect-disable setting is kept. Normal operation then resumes.
- R10: In normal operation, `dir_o` equals `dir_req_i`. `nxt_o` equals `nxt_req_i` when `cmd_en_o`=1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| por_i | input | 1 | Power-on reset, active high, synchronous |
| pin_rst_n_i | input | 1 | External reset pin, active low |
| pll_locked_i | input | 1 | PLL lock indication |
| stp_i | input | 1 | STP from the link |
| dir_req_i | input | 1 | DIR request from the packet layer |
| nxt_req_i | input | 1 | NXT request from the packet layer |
| swrst_wr_i | input | 1 | Write of 1 to the software-reset bit |
| prot_off_wr_i | input | 1 | Write of 1 to the protect-disable bit |
| dir_o | output | 1 | DIR pin value |
| nxt_o | output | 1 | NXT pin value |
| clk_en_o | output | 1 | Output clock enable (0 holds the clock high) |
| dpd_en_o | output | 1 | Data-line weak pull-down enable |
| stp_pu_en_o | output | 1 | STP pull-up enable |
| ulpi_hiz_o | output | 1 | Tri-state all ULPI outputs |
| reg_rst_o | output | 1 | Register-file reset |
| core_rst_o | output | 1 | Core-logic reset |
| cmd_en_o | output | 1 | Bus command decoding enabled |

## Verification
The bench builds the block with MIN_RST=4 and SW_CYCLES=5. With these values, a filtered pin pulse (three samples), the shortest accepted one (four) and the full software-reset window all fit in a few cycles. Random pin pulses around the threshold, STP patterns, write strobes and occasional power-on pulses then exercise every state transition many times. These include pin resets that cut into a software reset, and writes that land during holding.

// File: rtl/ulpi_rg_pkg.sv
package ulpi_rg_pkg;
  typedef enum logic [2:0] {
    ST_POR  = 3'd0,
    ST_PIN  = 3'd1,
    ST_WAIT = 3'd2,
    ST_RUN  = 3'd3,
    ST_SW   = 3'd4
  } rg_state_e;
endpackage

// File: rtl/ulpi_rg_pinflt.sv
module ulpi_rg_pinflt #(
  parameter int MIN_RST = 64
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic pin_rst_n_i,
  output logic pin_hit_o
);
  localparam int CW = (MIN_RST > 2) ? $clog2(MIN_RST) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_RST - 1);

  logic [CW-1:0] lo_cnt;

  // counts consecutive low samples, saturating one below the limit
  always_ff @(posedge clk_i) begin
    if (por_i || pin_rst_n_i) lo_cnt <= '0;
    else if (lo_cnt != LAST)  lo_cnt <= lo_cnt + 1'b1;
  end

  assign pin_hit_o = !pin_rst_n_i && (lo_cnt == LAST);
endmodule

// File: rtl/ulpi_rg_hold.sv
module ulpi_rg_hold (
  input  logic clk_i,
  input  logic por_i,
  input  logic force_i,
  input  logic stp_i,
  output logic hold_o
);
  logic stp_q;

  always_ff @(posedge clk_i) begin
    stp_q <= stp_i;
    if (por_i || force_i)             hold_o <= 1'b1;
    else if (hold_o && !stp_i)        hold_o <= 1'b0;
    else if (!hold_o && stp_i && stp_q) hold_o <= 1'b1;
  end
endmodule

// File: rtl/ulpi_rg_seq.sv
module ulpi_rg_seq
  import ulpi_rg_pkg::*;
#(
  parameter int SW_CYCLES = 16
) (
  input  logic      clk_i,
  input  logic      por_i,
  input  logic      pin_hit_i,
  input  logic      pll_locked_i,
  input  logic      hold_i,
  input  logic      swrst_wr_i,
  input  logic      prot_off_wr_i,
  output rg_state_e state_o,
  output logic      prot_off_o
);
  localparam int SCW = (SW_CYCLES > 2) ? $clog2(SW_CYCLES) : 1;
  localparam logic [SCW-1:0] SW_LAST = SCW'(SW_CYCLES - 1);

  logic [SCW-1:0] sw_cnt;
  rg_state_e      nxt_st;
  logic           cmd_ok;

  assign cmd_ok = (state_o == ST_RUN) && !hold_i;

  always_comb begin
    nxt_st = state_o;
    if (por_i)          nxt_st = ST_POR;
    else if (pin_hit_i) nxt_st = ST_PIN;
    else begin
      unique case (state_o)
        ST_POR, ST_PIN: nxt_st = ST_WAIT;
        ST_WAIT:        if (pll_locked_i) nxt_st = ST_RUN;
        ST_RUN:         if (swrst_wr_i && cmd_ok) nxt_st = ST_SW;
        ST_SW:          if (sw_cnt == SW_LAST) nxt_st = ST_RUN;
        default:        nxt_st = ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    state_o <= nxt_st;
    if (state_o == ST_SW && nxt_st == ST_SW) sw_cnt <= sw_cnt + 1'b1;
    else                                     sw_cnt <= '0;
    if (por_i || pin_hit_i)              prot_off_o <= 1'b0;
    else if (prot_off_wr_i && cmd_ok)    prot_off_o <= 1'b1;
  end
endmodule

// File: rtl/ulpi_rst_guard.sv
module ulpi_rst_guard
  import ulpi_rg_pkg::*;
#(
  parameter int MIN_RST   = 64,
  parameter int SW_CYCLES = 16
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic pin_rst_n_i,
  input  logic pll_locked_i,
  input  logic stp_i,
  input  logic dir_req_i,
  input  logic nxt_req_i,
  input  logic swrst_wr_i,
  input  logic prot_off_wr_i,
  output logic dir_o,
  output logic nxt_o,
  output logic clk_en_o,
  output logic dpd_en_o,
  output logic stp_pu_en_o,
  output logic ulpi_hiz_o,
  output logic reg_rst_o,
  output logic core_rst_o,
  output logic cmd_en_o
);
  logic      pin_hit;
  logic      hold;
  logic      prot_off;
  logic      force_hold;
  logic      guard;
  rg_state_e st;

  ulpi_rg_pinflt #(.MIN_RST(MIN_RST)) u_flt (
    .clk_i(clk_i), .por_i(por_i), .pin_rst_n_i(pin_rst_n_i), .pin_hit_o(pin_hit)
  );

  ulpi_rg_seq #(.SW_CYCLES(SW_CYCLES)) u_seq (
    .clk_i(clk_i), .por_i(por_i), .pin_hit_i(pin_hit), .pll_locked_i(pll_locked_i),
    .hold_i(hold), .swrst_wr_i(swrst_wr_i), .prot_off_wr_i(prot_off_wr_i),
    .state_o(st), .prot_off_o(prot_off)
  );

  assign force_hold = (st == ST_POR) || (st == ST_PIN) || (st == ST_WAIT);

  ulpi_rg_hold u_hold (
    .clk_i(clk_i), .por_i(por_i), .force_i(force_hold), .stp_i(stp_i), .hold_o(hold)
  );

  assign guard = hold && !prot_off;

  always_comb begin
    dir_o = 1'b1; nxt_o = 1'b0; clk_en_o = 1'b0; dpd_en_o = 1'b0;
    stp_pu_en_o = 1'b0; ulpi_hiz_o = 1'b0; reg_rst_o = 1'b0;
    core_rst_o = 1'b1; cmd_en_o = 1'b0;
    unique case (st)
      ST_POR: begin
        ulpi_hiz_o = 1'b1; reg_rst_o = 1'b1;
      end
      ST_PIN: begin
        dpd_en_o = 1'b1; stp_pu_en_o = 1'b1; reg_rst_o = 1'b1;
      end
      ST_WAIT: begin
        dpd_en_o = 1'b1; stp_pu_en_o = 1'b1;
      end
      ST_RUN: begin
        dir_o = dir_req_i; nxt_o = nxt_req_i && !hold; clk_en_o = 1'b1;
        dpd_en_o = guard; stp_pu_en_o = guard; core_rst_o = 1'b0; cmd_en_o = !hold;
      end
      ST_SW: begin
        clk_en_o = 1'b1; dpd_en_o = 1'b1; stp_pu_en_o = guard;
      end
      default: ulpi_hiz_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ulpi_rst_guard_chk.sv
module ulpi_rst_guard_chk (
  input logic clk_i,
  input logic por_i,
  input logic pin_rst_n_i,
  input logic pll_locked_i,
  input logic stp_i,
  input logic dir_o,
  input logic nxt_o,
  input logic clk_en_o,
  input logic dpd_en_o,
  input logic stp_pu_en_o,
  input logic ulpi_hiz_o,
  input logic reg_rst_o,
  input logic core_rst_o,
  input logic cmd_en_o
);
  p_hiz_pulls_off_r1: assert property (@(posedge clk_i) disable iff (por_i)
    ulpi_hiz_o |-> (!dpd_en_o && !stp_pu_en_o && reg_rst_o));

  p_pin_rise_needs_low_r2: assert property (@(posedge clk_i) disable iff (por_i)
    ($rose(reg_rst_o) && !ulpi_hiz_o) |-> $past(!pin_rst_n_i));

  p_pin_reset_pins_r3: assert property (@(posedge clk_i) disable iff (por_i)
    (reg_rst_o && !ulpi_hiz_o) |-> (dir_o && !nxt_o && !clk_en_o && dpd_en_o && stp_pu_en_o));

  p_clk_after_lock_r4: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(clk_en_o) |-> $past(pll_locked_i));

  p_hold_needs_stp_r6: assert property (@(posedge clk_i) disable iff (por_i)
    ($fell(cmd_en_o) && !core_rst_o) |-> $past(stp_i));

  p_swrst_accepted_r7: assert property (@(posedge clk_i) disable iff (por_i)
    ($rose(core_rst_o) && clk_en_o) |-> $past(cmd_en_o));

  p_swrst_pins_r9: assert property (@(posedge clk_i) disable iff (por_i)
    (core_rst_o && clk_en_o) |-> (dir_o && dpd_en_o && !reg_rst_o));

  p_nxt_gated_r10: assert property (@(posedge clk_i) disable iff (por_i)
    nxt_o |-> cmd_en_o);
endmodule

bind ulpi_rst_guard ulpi_rst_guard_chk chk_i (
  .clk_i(clk_i), .por_i(por_i), .pin_rst_n_i(pin_rst_n_i), .pll_locked_i(pll_locked_i),
  .stp_i(stp_i), .dir_o(dir_o), .nxt_o(nxt_o), .clk_en_o(clk_en_o), .dpd_en_o(dpd_en_o),
  .stp_pu_en_o(stp_pu_en_o), .ulpi_hiz_o(ulpi_hiz_o), .reg_rst_o(reg_rst_o),
  .core_rst_o(core_rst_o), .cmd_en_o(cmd_en_o)
);

// File: tb/ulpi_rst_guard_tb.sv
`timescale 1ns/1ps
module ulpi_rst_guard_tb_top;
  localparam int MIN_RST = 4;
  localparam int SW_CYC  = 5;

  logic clk = 1'b0;
  logic por = 1'b1, pin_n = 1'b1, locked = 1'b0, stp = 1'b0;
  logic dreq = 1'b0, nreq = 1'b0, swwr = 1'b0, pwr = 1'b0;
  logic dir_o, nxt_o, clk_en_o, dpd_en_o, stp_pu_en_o, ulpi_hiz_o, reg_rst_o, core_rst_o, cmd_en_o;

  int n_chk = 0, n_bad = 0;

  // bench model state: 0 por, 1 pin reset, 2 wait lock, 3 run, 4 soft reset
  int m_st = 0, m_lo = 0, m_sw = 0;
  bit m_hold = 1, m_stpq = 0, m_prot = 0;

  always #2 clk = ~clk;

  ulpi_rst_guard #(.MIN_RST(MIN_RST), .SW_CYCLES(SW_CYC)) dut_i (
    .clk_i(clk), .por_i(por), .pin_rst_n_i(pin_n), .pll_locked_i(locked), .stp_i(stp),
    .dir_req_i(dreq), .nxt_req_i(nreq), .swrst_wr_i(swwr), .prot_off_wr_i(pwr),
    .dir_o(dir_o), .nxt_o(nxt_o), .clk_en_o(clk_en_o), .dpd_en_o(dpd_en_o),
    .stp_pu_en_o(stp_pu_en_o), .ulpi_hiz_o(ulpi_hiz_o), .reg_rst_o(reg_rst_o),
    .core_rst_o(core_rst_o), .cmd_en_o(cmd_en_o)
  );

  function automatic logic [8:0] expect_vec();
    bit g;
    g = m_hold && !m_prot;
    case (m_st)
      0: return 9'b1_0_0_0_0_1_1_1_0;
      1: return 9'b1_0_0_1_1_0_1_1_0;
      2: return 9'b1_0_0_1_1_0_0_1_0;
      3: return {dreq, nreq && !m_hold, 1'b1, g, g, 1'b0, 1'b0, 1'b0, !m_hold};
      default: return {1'b1, 1'b0, 1'b1, 1'b1, g, 1'b0, 1'b0, 1'b1, 1'b0};
    endcase
  endfunction

  task automatic model_step();
    bit hit, cmd;
    int st_n;
    if (por) begin
      m_st = 0; m_lo = 0; m_prot = 0; m_hold = 1; m_sw = 0; m_stpq = stp;
      return;
    end
    hit = !pin_n && (m_lo == MIN_RST - 1);
    cmd = (m_st == 3) && !m_hold;
    if (hit) st_n = 1;
    else case (m_st)
      0, 1: st_n = 2;
      2: st_n = locked ? 3 : 2;
      3: st_n = (swwr && cmd) ? 4 : 3;
      default: st_n = (m_sw == SW_CYC - 1) ? 3 : 4;
    endcase
    m_sw = (m_st == 4 && st_n == 4) ? m_sw + 1 : 0;
    if (hit) m_prot = 0;
    else if (pwr && cmd) m_prot = 1;
    if (m_st <= 2) m_hold = 1;
    else if (m_hold && !stp) m_hold = 0;
    else if (!m_hold && stp && m_stpq) m_hold = 1;
    m_stpq = stp;
    m_lo = pin_n ? 0 : ((m_lo == MIN_RST - 1) ? m_lo : m_lo + 1);
    m_st = st_n;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(string tag);
    logic [8:0] act, exp;
    act = {dir_o, nxt_o, clk_en_o, dpd_en_o, stp_pu_en_o, ulpi_hiz_o, reg_rst_o, core_rst_o, cmd_en_o};
    exp = expect_vec();
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 power-on reset
    tick(); tick();
    check_all("R1"); check_bit("R1 hiz", ulpi_hiz_o, 1'b1); check_bit("R1 pd", dpd_en_o, 1'b0);
    // R4 wait for lock
    por = 0; tick();
    check_all("R4"); check_bit("R4 reg_rst", reg_rst_o, 1'b0); check_bit("R4 clk", clk_en_o, 1'b0);
    tick(); check_all("R4");
    locked = 1; tick();
    check_all("R4"); check_bit("R4 clk on", clk_en_o, 1'b1);
    // R5 leaves holding on first STP low sample
    check_bit("R5 held", cmd_en_o, 1'b0);
    tick(); check_all("R5"); check_bit("R5 cmd", cmd_en_o, 1'b1);
    // R6 holding entry
    stp = 1; tick(); check_all("R6"); check_bit("R6 one", cmd_en_o, 1'b1);
    stp = 0; tick(); check_all("R6"); check_bit("R6 single", cmd_en_o, 1'b1);
    stp = 1; tick(); tick(); check_all("R6"); check_bit("R6 two", cmd_en_o, 1'b0);
    check_bit("R6 pullup", stp_pu_en_o, 1'b1);
    // R7 write ignored while holding
    swwr = 1; pwr = 1; tick(); swwr = 0; pwr = 0;
    check_all("R7"); check_bit("R7 core", core_rst_o, 1'b0);
    stp = 0; tick(); check_all("R7"); check_bit("R7 prot kept", stp_pu_en_o, 1'b0);
    stp = 1; tick(); tick(); check_bit("R7 still protected", stp_pu_en_o, 1'b1);
    stp = 0; tick();
    // R10 pass-through
    dreq = 1; nreq = 1; #1; check_all("R10"); check_bit("R10 nxt", nxt_o, 1'b1);
    dreq = 0; nreq = 0;
    // R9 software reset
    swwr = 1; tick(); swwr = 0;
    check_all("R9"); check_bit("R9 core", core_rst_o, 1'b1); check_bit("R9 dir", dir_o, 1'b1);
    for (int i = 0; i < SW_CYC - 1; i++) begin tick(); check_all("R9"); check_bit("R9 len", core_rst_o, 1'b1); end
    tick(); check_all("R9"); check_bit("R9 end", core_rst_o, 1'b0);
    // R8 protection off
    pwr = 1; tick(); pwr = 0;
    stp = 1; tick(); tick(); check_all("R8"); check_bit("R8 pu", stp_pu_en_o, 1'b0); check_bit("R8 pd", dpd_en_o, 1'b0);
    stp = 0; tick();
    swwr = 1; tick(); swwr = 0; check_all("R9 prot"); 
    for (int i = 0; i < SW_CYC; i++) tick();
    // R2 short pin pulse
    pin_n = 0;
    for (int i = 0; i < MIN_RST - 1; i++) begin tick(); check_all("R2"); check_bit("R2 reg", reg_rst_o, 1'b0); end
    pin_n = 1; tick(); check_all("R2");
    // R3 valid pin reset
    pin_n = 0;
    for (int i = 0; i < MIN_RST; i++) tick();
    check_all("R3"); check_bit("R3 reg", reg_rst_o, 1'b1); check_bit("R3 pd", dpd_en_o, 1'b1);
    tick(); check_all("R3");
    pin_n = 1; tick(); check_all("R4"); tick(); check_all("R5");
    stp = 1; tick(); tick(); check_all("R8"); check_bit("R8 restored", stp_pu_en_o, 1'b1);
    stp = 0; tick();
    // R3 pin reset cuts into software reset
    swwr = 1; tick(); swwr = 0; pin_n = 0;
    for (int i = 0; i < MIN_RST; i++) tick();
    check_all("R3"); check_bit("R3 over sw", reg_rst_o, 1'b1);
    // R1 power-on overrides pin reset
    por = 1; tick(); check_all("R1"); check_bit("R1 prio", ulpi_hiz_o, 1'b1);
    por = 0; pin_n = 1; tick(); tick(); tick();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      stp  = ($urandom_range(0, 9) < 3);
      dreq = $urandom_range(0, 1);
      nreq = $urandom_range(0, 1);
      swwr = ($urandom_range(0, 99) < 3);
      pwr  = ($urandom_range(0, 99) < 3);
      locked = ($urandom_range(0, 9) < 8);
      if ($urandom_range(0, 99) < 4) pin_n = ~pin_n;
      por = ($urandom_range(0, 999) < 3);
      tick();
      check_all("R10 random");
    end
    finish_run();
  end
endmodule